// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is an SMBus target that owns a small register file (32 bytes by default). A bus master reaches the registers with indexed transfers: each transfer names a starting offset and, for writes, a byte count, after which data bytes move one after another while the offset steps forward by one per data byte and wraps from the last register back to register zero. A one-byte access is the same transfer with a count of one on a write, or a read that the master ends after the first data byte.

For a read, the master writes the target's write address and the offset, issues a repeated start with the read address, and then receives a count byte before the data. The count byte resets to 8 and afterwards holds the count of the last write the target accepted. The master ends a read by answering the byte it wants last with a NACK, and may stop at any point. SCL and SDA are sampled on the system clock through a synchronizer; SDA is driven only as an open-drain pull-down enable. Other logic on the chip reads any register through a parallel port that combinationally returns the addressed byte.

Top module: `smbreg_top`

## Requirements
- R1: An address byte other than the write address (D2h) or the read address (D3h) is not acknowledged, and the target acknowledges no byte and writes no register until the next start condition.
- R2: After the write address D2h, an offset byte and a nonzero count N, the target acknowledges every byte and stores N data bytes at offset, offset+1, and onwards.
- R3: A count byte of 0 is not acknowledged, no register changes, and the stored count byte never holds 0.
- R4: Data bytes beyond the count N of a write are not acknowledged and do not change any register.
- R5: The offset uses the low 5 bits of the offset byte, steps by one after every data byte written or read, and wraps from 31 to 0.
- R6: In a read (D2h, offset, repeated start, D3h) the target sends the count byte and then the registers from the offset onwards, most significant bit first, as long as the master acknowledges.
- R7: The count byte sent in a read is 8 after reset and afterwards equals the count of the last accepted write.
- R8: When the master NACKs a byte or a stop condition occurs, the target releases SDA (sda_oe_o low) and keeps it released until the next start condition.
- R9: After reset every register reads 0 on the parallel port, sda_oe_o is low, and the parallel port returns the register selected by pp_addr_i.
- R10: The target changes sda_oe_o only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| pp_addr_i | input | 5 | Parallel port register select |
| pp_data_o | output | 8 | Parallel port register contents |

## Verification
A wrong offset, count or state shows within one SMBus byte: a misplaced acknowledge appears on the ninth clock of the very byte being decoded, and a wrong pointer or a lost write shows on the parallel port right after the stop and on the data bits of the next read. The stored count byte is exposed as the first byte of every read, so a corrupted or wrongly updated count is visible on the next read transfer. A target that fails to release SDA shows as all-zero bits when the master clocks further bytes after its NACK.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_SKIP
  } st_e;

  typedef enum logic [1:0] {
    FLD_ADDR, FLD_OFFS, FLD_CNT, FLD_DATA
  } fld_e;
endpackage

// File: rtl/smbreg_sync.sv
module smbreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] sh_q [STAGES];
  logic [1:0] prev_q;
  logic [1:0] cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) sh_q[i] <= 2'b11;
      prev_q <= 2'b11;
    end else begin
      sh_q[0] <= {scl_i, sda_i};
      for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign cur        = sh_q[STAGES-1];
  assign scl_o      = cur[1];
  assign sda_o      = cur[0];
  assign scl_rise_o = cur[1] & ~prev_q[1];
  assign scl_fall_o = ~cur[1] & prev_q[1];
  // SDA edge while SCL stays high
  assign start_o    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
  assign stop_o     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
endmodule

// File: rtl/smbreg_regfile.sv
module smbreg_regfile #(
  parameter int NREG = 32,
  parameter int AW   = 5,
  parameter int DW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/smbreg_ctrl.sv
module smbreg_ctrl
  import smbreg_pkg::*;
#(
  parameter int                AW      = 5,
  parameter logic [BYTE_W-1:0] WR_BYTE = 8'hD2,
  parameter logic [BYTE_W-1:0] RD_BYTE = 8'hD3,
  parameter logic [BYTE_W-1:0] CNT_RST = 8'd8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [AW-1:0]     ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [BYTE_W-1:0] cnt_o
);
  st_e               st_q;
  fld_e              fld_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] sh_q, rem_q, cnt_q;
  logic [AW-1:0]     ptr_q;
  logic              rd_q, mack_q;
  logic              byte_end;

  assign byte_end = scl_fall_i && (bit_q == 4'd8);
  assign we_o     = (st_q == ST_RX) && byte_end && (fld_q == FLD_DATA) && (rem_q != '0);
  assign wdata_o  = sh_q;
  assign ptr_o    = ptr_q;
  assign cnt_o    = cnt_q;
  assign sda_oe_o = (st_q == ST_RXACK) || ((st_q == ST_TX) && !sh_q[BYTE_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      fld_q  <= FLD_ADDR;
      bit_q  <= '0;
      sh_q   <= '0;
      rem_q  <= '0;
      cnt_q  <= CNT_RST;
      ptr_q  <= '0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (start_i) begin
      st_q  <= ST_RX;
      fld_q <= FLD_ADDR;
      bit_q <= '0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            bit_q <= bit_q + 4'd1;
          end else if (byte_end) begin
            st_q <= ST_RXACK;
            unique case (fld_q)
              FLD_ADDR: begin
                if (sh_q == WR_BYTE) begin
                  fld_q <= FLD_OFFS;
                  rd_q  <= 1'b0;
                end else if (sh_q == RD_BYTE) begin
                  rd_q <= 1'b1;
                end else begin
                  st_q <= ST_SKIP;
                end
              end
              FLD_OFFS: begin
                ptr_q <= sh_q[AW-1:0];
                fld_q <= FLD_CNT;
              end
              FLD_CNT: begin
                if (sh_q == '0) begin
                  st_q <= ST_SKIP;
                end else begin
                  rem_q <= sh_q;
                  cnt_q <= sh_q;
                  fld_q <= FLD_DATA;
                end
              end
              default: begin
                if (rem_q != '0) begin
                  ptr_q <= ptr_q + 1'b1;
                  rem_q <= rem_q - 1'b1;
                end else begin
                  st_q <= ST_SKIP;
                end
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall_i) begin
            bit_q <= '0;
            if (rd_q) begin
              st_q <= ST_TX;
              sh_q <= cnt_q;
              rd_q <= 1'b0;
            end else begin
              st_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bit_q <= bit_q + 4'd1;
          end else if (byte_end) begin
            st_q <= ST_TXACK;
          end else if (scl_fall_i) begin
            sh_q <= {sh_q[BYTE_W-2:0], 1'b1};
          end
        end
        ST_TXACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              st_q  <= ST_TX;
              sh_q  <= rdata_i;
              ptr_q <= ptr_q + 1'b1;
              bit_q <= '0;
            end else begin
              st_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smbreg_top.sv
module smbreg_top
  import smbreg_pkg::*;
#(
  parameter int         NREG        = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] CNT_RST     = 8'd8,
  localparam int        AW          = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [AW-1:0]     pp_addr_i,
  output logic [BYTE_W-1:0] pp_data_o
);
  localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_BYTE = {DEV_ADDR, 1'b1};

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              we;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] wdata, bus_rdata, cnt;

  smbreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smbreg_ctrl #(
    .AW      (AW),
    .WR_BYTE (WR_BYTE),
    .RD_BYTE (RD_BYTE),
    .CNT_RST (CNT_RST)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_i      (sda_s),
    .rdata_i    (bus_rdata),
    .sda_oe_o   (sda_oe_o),
    .we_o       (we),
    .ptr_o      (ptr),
    .wdata_o    (wdata),
    .cnt_o      (cnt)
  );

  smbreg_regfile #(.NREG(NREG), .AW(AW), .DW(BYTE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (ptr),
    .wdata_i   (wdata),
    .raddr_a_i (ptr),
    .rdata_a_o (bus_rdata),
    .raddr_b_i (pp_addr_i),
    .rdata_b_o (pp_data_o)
  );
endmodule

// File: rtl/smbreg_chk.sv
module smbreg_chk #(
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s_i,
  input logic          stop_i,
  input logic          sda_oe_i,
  input logic          we_i,
  input logic [AW-1:0] ptr_i,
  input logic [7:0]    cnt_i
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !$past(scl_s_i)); // R10

  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i); // R8

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ptr_i == AW'($past(ptr_i) + 1'b1))); // R5

  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i != 8'd0); // R3
endmodule

bind smbreg_top smbreg_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s_i  (scl_s),
  .stop_i   (stop_det),
  .sda_oe_i (sda_oe_o),
  .we_i     (we),
  .ptr_i    (ptr),
  .cnt_i    (cnt)
);

// File: tb/tb_smbreg_top.sv
module tb_smbreg_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int NREG       = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_line;
  logic [4:0] pp_addr = '0;
  logic [7:0] pp_data;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smbreg_top dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .pp_addr_i (pp_addr),
    .pp_data_o (pp_data)
  );

  int         n_vec = 0;
  int         n_bad = 0;
  int         r10_bad = 0;
  logic       done = 1'b0;
  logic       prev_oe = 1'b0;
  logic [7:0] mdl [NREG];
  logic [7:0] mcnt = 8'd8;
  logic [7:0] wbuf [64];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R10 monitor on the raw master SCL
  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe !== prev_oe)) r10_bad++;
    prev_oe <= sda_oe;
  end

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic ack_m, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack_m);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < NREG; a++) begin
      pp_addr = 5'(a);
      wq(1);
      chk(tag, {24'd0, pp_data}, {24'd0, mdl[a]});
    end
  endtask

  // write: offset, count field, n data bytes from wbuf
  task automatic wr_txn(input logic [7:0] off, input int n, input logic [7:0] cnt);
    logic ack;
    logic [4:0] p;
    bus_start();
    send_byte(8'hD2, ack); chk("R2 write address ack", {31'd0, ack}, 32'd1);
    send_byte(off, ack);   chk("R2 offset ack", {31'd0, ack}, 32'd1);
    send_byte(cnt, ack);
    chk((cnt == 0) ? "R3 zero count nack" : "R2 count ack", {31'd0, ack}, {31'd0, cnt != 0});
    p = off[4:0];
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      if (cnt != 0 && i < int'(cnt)) begin
        chk("R2 data ack", {31'd0, ack}, 32'd1);
        mdl[p] = wbuf[i];
        p = p + 5'd1;
      end else begin
        chk((cnt == 0) ? "R3 data after zero count" : "R4 excess byte nack", {31'd0, ack}, 32'd0);
      end
    end
    if (cnt != 0) mcnt = cnt;
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] off, input int n);
    logic ack;
    logic [7:0] v;
    logic [4:0] p;
    bus_start();
    send_byte(8'hD2, ack); chk("R6 write address ack", {31'd0, ack}, 32'd1);
    send_byte(off, ack);   chk("R6 offset ack", {31'd0, ack}, 32'd1);
    bus_rstart();
    send_byte(8'hD3, ack); chk("R6 read address ack", {31'd0, ack}, 32'd1);
    recv_byte(1'b1, v);    chk("R7 count byte", {24'd0, v}, {24'd0, mcnt});
    p = off[4:0];
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      chk("R6 read data", {24'd0, v}, {24'd0, mdl[p]});
      p = p + 5'd1;
    end
    bus_stop();
    wq(Q);
    chk("R8 released after read", {31'd0, sda_oe}, 32'd0);
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    for (int a = 0; a < NREG; a++) mdl[a] = 8'h00;
    wq(3);
    chk("R9 sda released in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    wq(4);
    sweep("R9 reset contents");

    rd_txn(8'h00, 1);                       // R7 reset count

    for (int i = 0; i < NREG; i++) wbuf[i] = 8'(i * 7 + 3);
    wr_txn(8'h00, 32, 8'd32);
    sweep("R2 block write");

    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    wr_txn(8'd30, 4, 8'd4);
    sweep("R5 write wrap");

    wbuf[0] = 8'hEE;
    wr_txn(8'd3, 1, 8'd0);
    sweep("R3 zero count unchanged");

    for (int i = 0; i < 3; i++) wbuf[i] = 8'h50 + 8'(i);
    wr_txn(8'd5, 3, 8'd2);
    sweep("R4 excess unchanged");

    bus_start();
    send_byte(8'hA0, ack); chk("R1 foreign address nack", {31'd0, ack}, 32'd0);
    send_byte(8'h04, ack); chk("R1 no ack after foreign", {31'd0, ack}, 32'd0);
    send_byte(8'h01, ack); chk("R1 no ack after foreign", {31'd0, ack}, 32'd0);
    send_byte(8'h77, ack); chk("R1 no ack after foreign", {31'd0, ack}, 32'd0);
    bus_stop();
    sweep("R1 foreign unchanged");

    wbuf[0] = 8'h3C;
    wr_txn(8'h25, 1, 8'd1);                 // R5 offset upper bits dropped
    sweep("R5 offset low bits");

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_txn(8'd29, 3, 8'd3);
    rd_txn(8'd28, 6);                       // R6 R5 R7 read wrap

    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'd9, ack);
    bus_rstart();
    send_byte(8'hD3, ack);
    recv_byte(1'b1, v);
    recv_byte(1'b0, v);
    chk("R6 single byte read", {24'd0, v}, {24'd0, mdl[9]});
    recv_byte(1'b0, v);
    chk("R8 released after nack", {24'd0, v}, 32'h0000_00FF);
    bus_stop();

    for (int a = 0; a < NREG; a++) begin
      wbuf[0] = 8'(a * 37) ^ 8'h5A;
      wr_txn(8'(a), 1, 8'd1);
      rd_txn(8'(a), 1);
    end
    sweep("R2 single byte sweep");

    chk("R10 sda moved while scl high", r10_bad, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule